// File: doc/BRIEF.md
# Attribute Index/Data Port with Palette Index Mapping

This block holds the CPU-visible register file of a display attribute stage and turns each incoming pixel into an 8-bit colour-lookup index. The CPU reaches all registers through one byte-wide write port. An internal phase flip-flop makes that port alternate between two roles. Written in the index phase, the byte selects a register and carries a display-enable flag. Written in the data phase, the byte is stored in the selected register. A status-read strobe from elsewhere in the display subsystem puts the port back into the index phase. A combinational read port shows the selected register, and a toggle-status output shows the current phase, flag and index.

On the pixel side the block takes either a 4-bit planar pixel or an 8-bit packed pixel, together with an active-area flag. Planar pixels are masked by a plane-enable mask and then looked up in a sixteen-entry palette. The upper bits of the result come from a colour-select register, as the mode register directs. Packed pixels pass straight through. The border colour is produced outside the active area, and also whenever the display is disabled. The output is registered.

Top module: `attr_port`

## Requirements
- R1: After reset every register is 0, the port is in the index phase, `tgl_stat` and `rd_data` read 0, and `pix_index` is 0.
- R2: Each accepted write on `wr_en` flips the port phase. In the index phase the byte's bits 4:0 become the current index and bit 5 becomes the display-enable flag. In the data phase the byte is written to the indexed register.
- R3: `stat_rd` returns the port to the index phase. If it coincides with `wr_en`, the write is discarded.
- R4: Register map: indices 0x00-0x0F are 6-bit palette entries, 0x10 is mode (8 bits), 0x11 is border colour (8 bits), 0x12 is plane enable (bits 3:0), 0x13 is pan (bits 3:0) and 0x14 is colour select (bits 3:0). Data writes to any other index change nothing.
- R5: A palette data write is ignored while the display-enable flag is 1. Writes to the non-palette registers are accepted whichever value the flag has.
- R6: `rd_data` shows the indexed register, zero-extended, or 0 for unused indices. Reading has no side effect.
- R7: `tgl_stat` equals {phase, 1'b0, flag, index}. Bit 7 is 1 when the next write targets data.
- R8: With mode bit 6 = 0, an active pixel maps to {csel[3:2], hi, pal[p][3:0]}, where p = `pix_planar` & plane enable. hi is csel[1:0] when mode bit 7 = 1, and pal[p][5:4] otherwise.
- R9: With mode bit 6 = 1, an active pixel outputs `pix_packed` unchanged, and colour select has no effect.
- R10: When `pix_active` = 0 or the display-enable flag = 0, the output is the border register.
- R11: `pix_index` reflects the pixel inputs and registers of the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the shared index/data port |
| wr_data | input | 8 | Write byte |
| stat_rd | input | 1 | Status-read strobe; returns the port to the index phase |
| rd_data | output | 8 | Currently indexed register |
| tgl_stat | output | 8 | Phase, display flag and index |
| pix_planar | input | 4 | Planar pixel |
| pix_packed | input | 8 | Packed 8-bit pixel |
| pix_active | input | 1 | Pixel lies in the active area |
| pix_index | output | 8 | Registered colour-lookup index |

## Verification
The mapping is exercised with planar pixels across all sixteen values under several plane-enable masks. This separates masking errors from palette addressing errors. Both settings of mode bit 7 are used with distinct palette and colour-select contents, so that each half of the upper nibble shows where it was taken from. Packed pixels under random colour select confirm that the bypass ignores that register. Inactive pixels, and pixels with the display flag cleared, confirm that the border colour has priority. A random mix of index writes, data writes, strobes and strobe-write collisions, checked against a bench model, covers the phase tracking and the palette write protection.

// File: rtl/attr_port.sv
module attr_port #(
  parameter int PAL_N = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          stat_rd,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] tgl_stat,
  input  logic [3:0]    pix_planar,
  input  logic [DW-1:0] pix_packed,
  input  logic          pix_active,
  output logic [DW-1:0] pix_index
);
  localparam int PAW = $clog2(PAL_N);
  localparam logic [4:0] A_MODE = 5'(PAL_N);
  localparam logic [4:0] A_BORD = 5'(PAL_N + 1);
  localparam logic [4:0] A_PEN  = 5'(PAL_N + 2);
  localparam logic [4:0] A_PAN  = 5'(PAL_N + 3);
  localparam logic [4:0] A_CSEL = 5'(PAL_N + 4);

  logic          phase_q, disp_q;
  logic [4:0]    idx_q;
  logic [5:0]    pal [PAL_N];
  logic [DW-1:0] mode_q, bord_q;
  logic [3:0]    pen_q, pan_q, csel_q;

  wire take     = wr_en && !stat_rd;
  wire data_wr  = take && phase_q;
  wire pal_hit  = idx_q < 5'(PAL_N);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      disp_q  <= 1'b0;
      idx_q   <= '0;
    end else if (stat_rd) begin
      phase_q <= 1'b0;
    end else if (wr_en) begin
      phase_q <= !phase_q;
      if (!phase_q) begin
        idx_q  <= wr_data[4:0];
        disp_q <= wr_data[5];
      end
    end
  end

  generate
    for (genvar g = 0; g < PAL_N; g++) begin : g_pal
      always_ff @(posedge clk) begin
        if (!rst_n) pal[g] <= '0;
        else if (data_wr && !disp_q && idx_q == 5'(g)) pal[g] <= wr_data[5:0];
      end
      assert_pal_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pal[g]) |-> $past(!disp_q));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; bord_q <= '0; pen_q <= '0; pan_q <= '0; csel_q <= '0;
    end else if (data_wr) begin
      case (idx_q)
        A_MODE: mode_q <= wr_data;
        A_BORD: bord_q <= wr_data;
        A_PEN:  pen_q  <= wr_data[3:0];
        A_PAN:  pan_q  <= wr_data[3:0];
        A_CSEL: csel_q <= wr_data[3:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    if (pal_hit) rd_data = {2'b00, pal[idx_q[PAW-1:0]]};
    else case (idx_q)
      A_MODE: rd_data = mode_q;
      A_BORD: rd_data = bord_q;
      A_PEN:  rd_data = {4'h0, pen_q};
      A_PAN:  rd_data = {4'h0, pan_q};
      A_CSEL: rd_data = {4'h0, csel_q};
      default: rd_data = '0;
    endcase
  end

  assign tgl_stat = {phase_q, 1'b0, disp_q, idx_q};

  wire [3:0] pmask = pix_planar & pen_q;
  wire [5:0] pent  = pal[pmask[PAW-1:0]];
  wire [1:0] mid   = mode_q[7] ? csel_q[1:0] : pent[5:4];
  wire [DW-1:0] nxt = (!pix_active || !disp_q) ? bord_q :
                      mode_q[6] ? pix_packed : {csel_q[3:2], mid, pent[3:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) pix_index <= '0;
    else        pix_index <= nxt;
  end

  assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> tgl_stat[7] != $past(tgl_stat[7]));
  assert_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !tgl_stat[7]);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !stat_rd) |=> $stable(tgl_stat));
  assert_border_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_active |=> pix_index == $past(bord_q));
  assert_packed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_active && disp_q && mode_q[6]) |=> pix_index == $past(pix_packed));
endmodule

// File: tb/attr_port_tb.sv
module attr_port_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, stat_rd = 0, pix_active = 0;
  logic [7:0] wr_data = 0, pix_packed = 0;
  logic [3:0] pix_planar = 0;
  logic [7:0] rd_data, tgl_stat, pix_index;
  int n_chk = 0, n_fail = 0;

  attr_port dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stat_rd(stat_rd), .rd_data(rd_data), .tgl_stat(tgl_stat),
    .pix_planar(pix_planar), .pix_packed(pix_packed), .pix_active(pix_active),
    .pix_index(pix_index));

  always #10 clk = ~clk;

  logic m_ph, m_disp;
  logic [4:0] m_idx;
  logic [5:0] m_pal [16];
  logic [7:0] m_mode, m_bord;
  logic [3:0] m_pen, m_pan, m_cs;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] m_rd();
    if (m_idx < 16) return {2'b00, m_pal[m_idx[3:0]]};
    case (m_idx)
      5'h10: return m_mode;
      5'h11: return m_bord;
      5'h12: return {4'h0, m_pen};
      5'h13: return {4'h0, m_pan};
      5'h14: return {4'h0, m_cs};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] m_pix(logic [3:0] pl, logic [7:0] pk, logic act);
    logic [5:0] p;
    logic [1:0] hi;
    if (!act || !m_disp) return m_bord;
    if (m_mode[6]) return pk;
    p = m_pal[pl & m_pen];
    hi = m_mode[7] ? m_cs[1:0] : p[5:4];
    return {m_cs[3:2], hi, p[3:0]};
  endfunction

  task automatic m_reset();
    m_ph = 0; m_disp = 0; m_idx = 0;
    m_mode = 0; m_bord = 0; m_pen = 0; m_pan = 0; m_cs = 0;
    for (int i = 0; i < 16; i++) m_pal[i] = 0;
  endtask

  task automatic cycle(logic w, logic [7:0] b, logic s);
    @(negedge clk);
    wr_en = w; wr_data = b; stat_rd = s;
    @(negedge clk);
    wr_en = 0; stat_rd = 0;
    if (s) m_ph = 0;
    else if (w) begin
      if (!m_ph) begin m_idx = b[4:0]; m_disp = b[5]; end
      else if (m_idx < 16) begin if (!m_disp) m_pal[m_idx[3:0]] = b[5:0]; end
      else case (m_idx)
        5'h10: m_mode = b;
        5'h11: m_bord = b;
        5'h12: m_pen = b[3:0];
        5'h13: m_pan = b[3:0];
        5'h14: m_cs = b[3:0];
        default: ;
      endcase
      m_ph = !m_ph;
    end
  endtask

  task automatic setreg(logic [4:0] a, logic [7:0] v);
    cycle(0, 0, 1);
    cycle(1, {2'b00, 1'b0, a}, 0);
    cycle(1, v, 0);
  endtask

  task automatic enable_disp();
    cycle(0, 0, 1);
    cycle(1, 8'h20, 0);
    cycle(0, 0, 1);
  endtask

  task automatic pix(string req, logic [3:0] pl, logic [7:0] pk, logic act);
    logic [7:0] e;
    @(negedge clk);
    pix_planar = pl; pix_packed = pk; pix_active = act;
    e = m_pix(pl, pk, act);
    @(negedge clk);
    chk(req, pix_index, e);
  endtask

  task automatic rdchk(string req);
    chk({req, " rd"}, rd_data, m_rd());
    chk({req, " stat"}, tgl_stat, {m_ph, 1'b0, m_disp, m_idx});
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 stat", tgl_stat, 8'h00);
    chk("R1 rd", rd_data, 8'h00);
    chk("R1 pix", pix_index, 8'h00);

    cycle(1, 8'h03, 0);
    chk("R2 index phase", tgl_stat, 8'h83);
    cycle(1, 8'h2A, 0);
    chk("R2 data phase", tgl_stat, 8'h03);
    chk("R4 pal3", rd_data, 8'h2A);
    cycle(1, 8'h11, 0);
    cycle(0, 0, 1);
    chk("R3 strobe", tgl_stat, 8'h11);
    cycle(1, 8'h05, 1);
    chk("R3 collision", tgl_stat, 8'h11);
    rdchk("R6 idle read");
    rdchk("R6 no side effect");

    for (int i = 0; i < 16; i++) setreg(5'(i), 8'(8'h30 + i * 3));
    setreg(5'h11, 8'h5C);
    setreg(5'h12, 8'h0F);
    setreg(5'h14, 8'h09);
    setreg(5'h15, 8'hFF);
    rdchk("R4 unused index");
    setreg(5'h13, 8'h07);
    rdchk("R4 pan");
    pix("R10 disp off", 4'h5, 8'h00, 1);
    enable_disp();
    chk("R7 flag", tgl_stat, 8'h20);
    cycle(1, 8'h22, 0);
    cycle(1, 8'h01, 0);
    rdchk("R5 pal locked");
    cycle(0, 0, 1);
    for (int i = 0; i < 16; i++) pix("R8 planar", 4'(i), 8'h00, 1);
    cycle(1, 8'h32, 0); cycle(1, 8'h05, 0); cycle(0, 0, 1);
    for (int i = 0; i < 16; i++) pix("R8 plane mask", 4'(i), 8'h00, 1);
    cycle(1, 8'h30, 0); cycle(1, 8'h80, 0); cycle(0, 0, 1);
    pix("R8 csel hi", 4'h1, 8'h00, 1);
    pix("R10 inactive", 4'h1, 8'h00, 0);
    cycle(1, 8'h30, 0); cycle(1, 8'hC0, 0); cycle(0, 0, 1);
    pix("R9 packed", 4'h2, 8'hA7, 1);
    pix("R11 latency", 4'h2, 8'h3C, 1);

    for (int k = 0; k < 1500; k++) begin
      case ($urandom % 5)
        0: cycle(1, m_ph ? 8'($urandom) : {2'b00, 1'($urandom), 5'($urandom % 22)}, 0);
        1: cycle(1, 8'($urandom), ($urandom % 4) == 0);
        2: cycle(0, 0, 1);
        3: pix("R8 R9 R10 random", 4'($urandom), 8'($urandom), ($urandom % 4) != 0);
        default: begin @(negedge clk); rdchk("R6 R7 random"); end
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule